// File: doc/BRIEF.md
# PWM Dead-Time and Fault Extension

This block sits behind the compare-channel waveform outputs of a timer (four channels by default) and produces the drive values for eight output pins, plus an enable for each pin that tells the port logic to take the pin's value from this block. In pair mode, each channel's waveform becomes a complementary low-side/high-side pair. The side that turns on is delayed by a programmable dead time, with separate 8-bit values for the low side and the high side. In fan-out mode, the processed pair of channel 0 drives every pin pair. In pattern mode, dead-time insertion is bypassed, and a buffered bit pattern chooses which pins carry their channel's raw waveform.

Fault inputs can be enabled individually through a mask. Any enabled fault that goes active forces every pin value to 0, and the fault stays latched until software clears it. Both dead times and the pattern are double buffered: software writes a shadow copy, and the active copy is loaded only on the timer's update strobe. Software reaches the block through a simple byte-write port:

| Address | Content |
|---|---|
| 0 | mode[1:0] |
| 1 | pin enable mask for pair and fan-out modes |
| 2 | low-side dead-time shadow |
| 3 | high-side dead-time shadow |
| 4 | pattern shadow |
| 5 | fault mask[3:0] |
| 6 | fault clear (any data) |

Top module: `pwmx_dtfault`

## Requirements
- R1: In mode 1 (pair), pin 2k carries channel k's waveform (low side) and pin 2k+1 carries its inverse (high side), and the pin enables equal the enable mask at address 1.
- R2: After channel k's waveform rises, pin 2k+1 falls 2 clock edges later. Pin 2k rises LS+2 edges later, where LS is the active low-side dead time. Edges are counted from the first edge that samples the new waveform value, and LS=0 means no added delay.
- R3: After the waveform falls, pin 2k falls 2 edges later and pin 2k+1 rises HS+2 edges later, where HS is the active high-side dead time. HS is independent of LS.
- R4: A dead-time value written to its shadow address has no effect until the update strobe has been seen.
- R5: A waveform pulse that lasts fewer cycles than the dead time of the side it would turn on never asserts that side.
- R6: A fault input whose mask bit is set drives all pins to 0 on the first edge that samples it. A fault input whose mask bit is clear has no effect. The pin enables are unchanged by a fault.
- R7: A latched fault stays latched until a write to address 6 occurs while no enabled fault input is active. A clear written during an active fault is ignored. Normal outputs return one edge after the accepted clear.
- R8: In mode 2 (pattern), the pin enables equal the active pattern, and pin i equals pattern bit i AND channel i/2's raw waveform, with one edge of latency and no dead time. The pattern shadow is loaded only on the update strobe.
- R9: In mode 3 (fan-out), every even pin carries channel 0's delayed low side and every odd pin carries channel 0's delayed high side. The pin enables equal the mask at address 1.
- R10: After reset, and in mode 0 (off), all pins and pin enables are 0. Reset also clears both dead times, the pattern and the fault mask.
- R11: The low side and high side of a channel are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_i | input | 4 | Compare-channel waveforms from the timer |
| upd_i | input | 1 | Timer update strobe that loads the shadow registers |
| fault_i | input | 4 | Fault event inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| pin_o | output | 8 | Pin drive values |
| pin_oe_o | output | 8 | Per-pin enables that let this block take over the pin |

## Verification
The assertions assume that every input, including the waveforms and fault events, is synchronous to `clk` and stable around each rising edge, and that the write strobe lasts one cycle per register access. The bench changes every input one nanosecond after a rising edge and raises the write and update strobes for exactly one cycle. Dead-time values are changed only after the waveforms have been stable for longer than the new values. This keeps the outputs that are already settled from being withdrawn by a larger delay.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PAIR = 2'd1,
    MODE_PATT = 2'd2,
    MODE_FAN  = 2'd3
  } pwmx_mode_e;

  localparam int          AW       = 3;
  localparam logic [AW-1:0] A_MODE  = 3'd0;
  localparam logic [AW-1:0] A_OUTEN = 3'd1;
  localparam logic [AW-1:0] A_DTLS  = 3'd2;
  localparam logic [AW-1:0] A_DTHS  = 3'd3;
  localparam logic [AW-1:0] A_PATT  = 3'd4;
  localparam logic [AW-1:0] A_FMASK = 3'd5;
  localparam logic [AW-1:0] A_FCLR  = 3'd6;
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
  import pwmx_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DTW  = 8,
  parameter int NFLT = 4,
  parameter int DW   = 8,
  localparam int NPIN = 2 * NCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            upd,
  output pwmx_mode_e      mode,
  output logic [NPIN-1:0] outen,
  output logic [DTW-1:0]  dt_ls,
  output logic [DTW-1:0]  dt_hs,
  output logic [NPIN-1:0] patt,
  output logic [NFLT-1:0] fmask,
  output logic            fclr
);
  logic [DTW-1:0]  dt_ls_sh, dt_hs_sh;
  logic [NPIN-1:0] patt_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_OFF;
      outen    <= '0;
      dt_ls_sh <= '0;
      dt_hs_sh <= '0;
      patt_sh  <= '0;
      fmask    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode     <= pwmx_mode_e'(wr_data[1:0]);
        A_OUTEN: outen    <= wr_data[NPIN-1:0];
        A_DTLS:  dt_ls_sh <= wr_data[DTW-1:0];
        A_DTHS:  dt_hs_sh <= wr_data[DTW-1:0];
        A_PATT:  patt_sh  <= wr_data[NPIN-1:0];
        A_FMASK: fmask    <= wr_data[NFLT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_ls <= '0;
      dt_hs <= '0;
      patt  <= '0;
    end else if (upd) begin
      dt_ls <= dt_ls_sh;
      dt_hs <= dt_hs_sh;
      patt  <= patt_sh;
    end
  end

  assign fclr = wr_en && (wr_addr == A_FCLR);

  // R4: active dead times move only on the update strobe
  a_r4_dt_held: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(dt_ls) && $stable(dt_hs)));
endmodule

// File: rtl/pwmx_dti.sv
module pwmx_dti #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wave_i,
  input  logic [DTW-1:0] dt_ls,
  input  logic [DTW-1:0] dt_hs,
  output logic           ls_o,
  output logic           hs_o
);
  logic           wave_q;
  logic [DTW-1:0] age, age_n;

  // cycles the waveform has held its level, saturating
  always_comb begin
    if (wave_i != wave_q)     age_n = '0;
    else if (age == {DTW{1'b1}}) age_n = age;
    else                      age_n = age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      age    <= '0;
      ls_o   <= 1'b0;
      hs_o   <= 1'b0;
    end else begin
      wave_q <= wave_i;
      age    <= age_n;
      ls_o   <= wave_i && (age_n >= dt_ls);
      hs_o   <= !wave_i && (age_n >= dt_hs);
    end
  end

  // R11: sides never overlap
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(ls_o && hs_o));
  // R2: low side only follows a high waveform
  a_r2_ls_follows_wave: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_o) |-> $past(wave_i));
  // R3: high side only follows a low waveform
  a_r3_hs_follows_wave: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_o) |-> !$past(wave_i));
endmodule

// File: rtl/pwmx_fault.sv
module pwmx_fault #(
  parameter int NFLT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLT-1:0] fault_i,
  input  logic [NFLT-1:0] fmask,
  input  logic            fclr,
  output logic            fault_any
);
  logic active, latched;

  assign active = |(fault_i & fmask);

  always_ff @(posedge clk) begin
    if (rst)         latched <= 1'b0;
    else if (active) latched <= 1'b1;
    else if (fclr)   latched <= 1'b0;
  end

  assign fault_any = latched | active;

  // R7: a clear during an active fault leaves the latch set
  a_r7_clear_blocked: assert property (@(posedge clk) disable iff (rst)
    (fclr && active) |=> latched);
  // R7: without a clear the latch never drops
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (latched && !fclr) |=> latched);
endmodule

// File: rtl/pwmx_dtfault.sv
module pwmx_dtfault
  import pwmx_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DTW  = 8,
  parameter int NFLT = 4,
  parameter int DW   = 8,
  localparam int NPIN = 2 * NCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  wave_i,
  input  logic            upd_i,
  input  logic [NFLT-1:0] fault_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe_o
);
  pwmx_mode_e      mode;
  logic [NPIN-1:0] outen, patt, pin_d, oe_d;
  logic [DTW-1:0]  dt_ls, dt_hs;
  logic [NFLT-1:0] fmask;
  logic            fclr, fault_any;
  logic [NCH-1:0]  ls, hs;

  pwmx_regs #(.NCH(NCH), .DTW(DTW), .NFLT(NFLT), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .upd(upd_i), .mode(mode), .outen(outen),
    .dt_ls(dt_ls), .dt_hs(dt_hs), .patt(patt), .fmask(fmask), .fclr(fclr)
  );

  pwmx_fault #(.NFLT(NFLT)) u_fault (
    .clk(clk), .rst(rst), .fault_i(fault_i), .fmask(fmask),
    .fclr(fclr), .fault_any(fault_any)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_dti
    pwmx_dti #(.DTW(DTW)) u_dti (
      .clk(clk), .rst(rst), .wave_i(wave_i[g]), .dt_ls(dt_ls),
      .dt_hs(dt_hs), .ls_o(ls[g]), .hs_o(hs[g])
    );
  end

  always_comb begin
    pin_d = '0;
    oe_d  = '0;
    case (mode)
      MODE_PAIR: begin
        oe_d = outen;
        for (int k = 0; k < NCH; k++) begin
          pin_d[2*k]   = ls[k];
          pin_d[2*k+1] = hs[k];
        end
      end
      MODE_PATT: begin
        oe_d = patt;
        for (int i = 0; i < NPIN; i++) pin_d[i] = patt[i] & wave_i[i/2];
      end
      MODE_FAN: begin
        oe_d = outen;
        for (int k = 0; k < NCH; k++) begin
          pin_d[2*k]   = ls[0];
          pin_d[2*k+1] = hs[0];
        end
      end
      default: ;
    endcase
    if (fault_any) pin_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o    <= '0;
      pin_oe_o <= '0;
    end else begin
      pin_o    <= pin_d;
      pin_oe_o <= oe_d;
    end
  end

  // R6: a fault seen at an edge leaves every pin at 0 after the next one
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (rst)
    fault_any |=> (pin_o == '0));
  // R10: off mode releases every pin
  a_r10_off_release: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> (pin_oe_o == '0));
  // R8: pattern mode enables follow the active pattern
  a_r8_patt_oe: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PATT) |=> (pin_oe_o == $past(patt)));
endmodule

// File: tb/tb_pwmx_dtfault.sv
module tb_pwmx_dtfault;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] wave = '0;
  logic       upd = 1'b0;
  logic [3:0] flt = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] pin, oe;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwmx_dtfault dut (
    .clk(clk), .rst(rst), .wave_i(wave), .upd_i(upd), .fault_i(flt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pin_o(pin), .pin_oe_o(oe)
  );

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    upd = 1'b1;
    tick();
    upd = 1'b0;
  endtask

  function automatic logic [7:0] pair_of(logic [3:0] w);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin
      r[2*k]   = w[k];
      r[2*k+1] = ~w[k];
    end
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick();
    chk("R10 reset pins", pin, 8'h00);
    chk("R10 reset enables", oe, 8'h00);
  endtask

  task automatic t_pair();
    wr(3'd0, 8'd1);
    wr(3'd1, 8'hFF);
    tick(4);
    chk("R1 idle pair", pin, 8'hAA);
    chk("R1 enables", oe, 8'hFF);
    wave = 4'b0101;
    tick();
    chk("R2 no change after one edge", pin, 8'hAA);
    tick();
    chk("R2 zero dead time", pin, 8'h99);
  endtask

  task automatic t_buffer();
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd5);
    wave[0] = 1'b0;
    tick(2);
    chk("R4 shadow not active", {7'd0, pin[1]}, 8'd1);
    tick(10);
    strobe();
    wave[0] = 1'b1;
    tick(2);
    chk("R2 high side drops", {7'd0, pin[1]}, 8'd0);
    tick(2);
    chk("R2 low side still held", {7'd0, pin[0]}, 8'd0);
    tick();
    chk("R2 low side after LS=3", {7'd0, pin[0]}, 8'd1);
    tick(10);
    wave[0] = 1'b0;
    tick(2);
    chk("R3 low side drops", {7'd0, pin[0]}, 8'd0);
    tick(4);
    chk("R3 high side still held", {7'd0, pin[1]}, 8'd0);
    tick();
    chk("R3 high side after HS=5", {7'd0, pin[1]}, 8'd1);
    tick(10);
  endtask

  task automatic t_short();
    logic seen = 1'b0;
    wave[0] = 1'b1;
    tick(2);
    seen |= pin[0];
    wave[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      seen |= pin[0];
    end
    chk("R5 short pulse suppressed", {7'd0, seen}, 8'd0);
    tick(10);
  endtask

  task automatic t_fault();
    wr(3'd5, 8'b0010);
    flt = 4'b0001;
    tick(2);
    chk("R6 masked fault ignored", pin, pair_of(wave));
    flt = 4'b0010;
    tick();
    chk("R6 fault zeroes pins", pin, 8'h00);
    chk("R6 enables kept", oe, 8'hFF);
    wr(3'd6, 8'h00);
    flt = 4'b0000;
    tick(2);
    chk("R7 clear during fault ignored", pin, 8'h00);
    wr(3'd6, 8'h00);
    chk("R7 still zero at clear edge", pin, 8'h00);
    tick();
    chk("R7 outputs restored", pin, pair_of(wave));
  endtask

  task automatic t_pattern();
    wr(3'd4, 8'hC5);
    wr(3'd0, 8'd2);
    tick();
    chk("R8 pattern waits for strobe", oe, 8'h00);
    strobe();
    tick();
    chk("R8 pattern enables", oe, 8'hC5);
    wave = 4'b1111;
    tick();
    chk("R8 pattern all high", pin, 8'hC5);
    wave = 4'b1110;
    tick();
    chk("R8 bypass dead time", pin, 8'hC4);
  endtask

  task automatic t_fan();
    wr(3'd2, 8'd0);
    wr(3'd3, 8'd0);
    strobe();
    wr(3'd0, 8'd3);
    wave = 4'b0001;
    tick(3);
    chk("R9 fan-out high", pin, 8'h55);
    chk("R9 fan-out enables", oe, 8'hFF);
    wave = 4'b1110;
    tick();
    chk("R9 one edge later", pin, 8'h55);
    tick();
    chk("R9 fan-out follows channel 0", pin, 8'hAA);
  endtask

  task automatic t_off();
    wr(3'd0, 8'd0);
    tick();
    chk("R10 off pins", pin, 8'h00);
    chk("R10 off enables", oe, 8'h00);
  endtask

  initial begin
    t_reset();
    t_pair();
    t_buffer();
    t_short();
    t_fault();
    t_pattern();
    t_fan();
    t_off();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule